// File: doc/BRIEF.md
# Page Write Staging Buffer and Timed Commit Sequencer

This block sits between a serial-bus protocol engine and a nonvolatile array. The protocol engine gives it a start address, then one strobe per received data byte, and finally a commit strobe when a stop condition closes a write. Bytes are staged in a one-page buffer. Only the low offset bits of the address advance from byte to byte, so a long burst wraps inside the page and a later byte replaces an earlier one. A per-byte mask records which page locations were touched.

On commit, the block scans the page buffer once, in ascending offset order. It drives the memory write port for each touched location, except a location that falls in the protected upper region of the array while write protect is set. A fixed busy interval follows the scan and stands for the internally timed write cycle. While busy is high, every incoming strobe is refused. The block also returns the address the next current-address read should use.

Top module: `pgw_sequencer`

## Requirements
- R1: Reset leaves busy low, mem_we low and cur_addr at 0. An idle load_addr sets cur_addr to start_addr on the next cycle and discards every byte staged before it.
- R2: Each accepted byte_stb adds 1, modulo PAGE_BYTES, to the low log2(PAGE_BYTES) bits of cur_addr. The upper page bits stay unchanged.
- R3: When the offset wraps past the last byte of the page, a later byte staged at the same offset replaces the earlier one. Only the newest value is written.
- R4: A commit_stb accepted with at least one byte staged raises busy on the next cycle. Busy then stays high for exactly PAGE_BYTES + BUSY_CYCLES cycles.
- R5: During the commit, each staged location is written exactly once, at {page, offset}, in ascending offset order. Locations that were not staged are left unwritten.
- R6: While busy is high, load_addr, byte_stb and commit_stb are ignored. cur_addr does not change and nothing is staged.
- R7: A commit_stb with no byte staged starts no write cycle. Busy stays low and no write occurs.
- R8: wp is sampled in the cycle the commit is accepted. When it is 1, staged bytes whose address has its top log2(PROT_FRAC) bits all set (the upper 1/PROT_FRAC of the array) are dropped, and the other staged bytes are still written.
- R9: When wp is 0 at commit, every staged byte is written, in any region.
- R10: After a commit, cur_addr is the location after the last staged byte, wrapped within the page. The staged mask is empty afterwards.
- R11: mem_we is asserted only while busy is high, and the page bits of mem_addr stay fixed throughout a busy interval.
- R12: If strobes coincide in an idle cycle, load_addr takes precedence over byte_stb, and byte_stb over commit_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_addr | input | 1 | Start of a write: latch start_addr |
| start_addr | input | ADDR_W | Array address of the first byte |
| byte_stb | input | 1 | One received data byte is valid |
| byte_data | input | 8 | Data byte |
| commit_stb | input | 1 | Stop ended a write: commit staged bytes |
| wp | input | 1 | Write protect level |
| busy | output | 1 | Commit scan or timed write in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| cur_addr | output | ADDR_W | Address for the next current-address read |

## Verification
On every cycle, the assertions check the following:
- writes happen only while busy, and the page stays fixed across a busy interval;
- busy rises only after a commit strobe, and its length is exact;
- cur_addr is frozen while busy, and only the offset steps when a byte is accepted;
- no write reaches the protected region while the latched protect level is high.

Only the bench scenarios can show what ends up in the array. This includes wrap-around overwrites, untouched bytes keeping their contents, a wp change after commit having no effect, discarded bytes after a reload, and empty commits doing nothing.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SCAN = 2'd1,
      SQ_HOLD = 2'd2
   } sq_state_t;
endpackage

// File: rtl/pgw_stage.sv
module pgw_stage #(
   parameter int ADDR_W     = 13,
   parameter int PAGE_BYTES = 32,
   localparam int PAGE_AW   = $clog2(PAGE_BYTES),
   localparam int BASE_W    = ADDR_W - PAGE_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [ADDR_W-1:0]  load_addr,
   input  logic               byte_en,
   input  logic [7:0]         byte_data,
   input  logic               clr,
   input  logic [PAGE_AW-1:0] rd_idx,
   output logic [BASE_W-1:0]  page_base,
   output logic [PAGE_AW-1:0] wr_off,
   output logic               any_valid,
   output logic               rd_valid,
   output logic [7:0]         rd_data
);
   logic [PAGE_BYTES-1:0] valid_q;
   logic [7:0]            data_q [PAGE_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_base <= '0;
         wr_off    <= '0;
      end else if (load_en) begin
         page_base <= load_addr[ADDR_W-1:PAGE_AW];
         wr_off    <= load_addr[PAGE_AW-1:0];
      end else if (byte_en) begin
         wr_off    <= wr_off + 1'b1;
      end
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            data_q[g]  <= '0;
         end else if (load_en) begin
            valid_q[g] <= 1'b0;
         end else if (byte_en && (wr_off == PAGE_AW'(g))) begin
            valid_q[g] <= 1'b1;
            data_q[g]  <= byte_data;
         end else if (clr) begin
            valid_q[g] <= 1'b0;
         end
      end
   end

   assign any_valid = |valid_q;
   assign rd_valid  = valid_q[rd_idx];
   assign rd_data   = data_q[rd_idx];
endmodule

// File: rtl/pgw_protect.sv
module pgw_protect #(
   parameter int PROT_FRAC = 4,
   localparam int SEL_W    = $clog2(PROT_FRAC)
) (
   input  logic [SEL_W-1:0] msbs,
   output logic             hit
);
   initial assert ((PROT_FRAC >= 2) && ((PROT_FRAC & (PROT_FRAC - 1)) == 0))
      else $error("PROT_FRAC must be a power of two of at least 2");

   if (SEL_W == 1) begin : g_half
      assign hit = msbs[0];
   end else begin : g_frac
      assign hit = &msbs;
   end
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer
   import pgw_pkg::*;
#(
   parameter int PAGE_BYTES  = 32,
   parameter int BUSY_CYCLES = 1000000,
   localparam int PAGE_AW    = $clog2(PAGE_BYTES),
   localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   output logic               busy,
   output logic               scan_en,
   output logic [PAGE_AW-1:0] scan_idx,
   output logic               scan_last
);
   localparam logic [PAGE_AW-1:0] LAST_IDX = PAGE_AW'(PAGE_BYTES - 1);
   localparam logic [CNT_W-1:0]   LAST_CNT = CNT_W'(BUSY_CYCLES - 1);

   initial assert (BUSY_CYCLES >= 1) else $error("BUSY_CYCLES must be at least 1");

   sq_state_t        st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         scan_idx <= '0;
         cnt_q    <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (go) begin
               st_q     <= SQ_SCAN;
               scan_idx <= '0;
            end
            SQ_SCAN: if (scan_idx == LAST_IDX) begin
               st_q  <= SQ_HOLD;
               cnt_q <= '0;
            end else begin
               scan_idx <= scan_idx + 1'b1;
            end
            SQ_HOLD: if (cnt_q == LAST_CNT) begin
               st_q <= SQ_IDLE;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != SQ_IDLE);
   assign scan_en   = (st_q == SQ_SCAN);
   assign scan_last = scan_en && (scan_idx == LAST_IDX);
endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer #(
   parameter int ADDR_W      = 13,
   parameter int PAGE_BYTES  = 32,
   parameter int BUSY_CYCLES = 1000000,
   parameter int PROT_FRAC   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_addr,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_stb,
   input  logic [7:0]        byte_data,
   input  logic              commit_stb,
   input  logic              wp,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int PAGE_AW = $clog2(PAGE_BYTES);
   localparam int BASE_W  = ADDR_W - PAGE_AW;
   localparam int SEL_W   = $clog2(PROT_FRAC);

   initial assert ((PAGE_BYTES >= 2) && ((PAGE_BYTES & (PAGE_BYTES - 1)) == 0))
      else $error("PAGE_BYTES must be a power of two");
   initial assert (BASE_W >= SEL_W && BASE_W >= 1)
      else $error("ADDR_W too small for the page and protect region");

   logic               load_en, byte_en, go;
   logic               any_valid, rd_valid, scan_en, scan_last, prot_hit, wp_q;
   logic [BASE_W-1:0]  page_base;
   logic [PAGE_AW-1:0] wr_off, scan_idx;
   logic [7:0]         rd_data;

   assign load_en = load_addr && !busy;
   assign byte_en = byte_stb && !busy && !load_addr;
   assign go      = commit_stb && !busy && !load_addr && !byte_stb && any_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wp_q <= 1'b0;
      else if (go) wp_q <= wp;
   end

   pgw_stage #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_addr(start_addr),
      .byte_en(byte_en), .byte_data(byte_data),
      .clr(scan_last), .rd_idx(scan_idx),
      .page_base(page_base), .wr_off(wr_off),
      .any_valid(any_valid), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   pgw_timer #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(go),
      .busy(busy), .scan_en(scan_en), .scan_idx(scan_idx), .scan_last(scan_last)
   );

   pgw_protect #(.PROT_FRAC(PROT_FRAC)) u_prot (
      .msbs(mem_addr[ADDR_W-1 -: SEL_W]),
      .hit(prot_hit)
   );

   assign mem_addr  = {page_base, scan_idx};
   assign mem_wdata = rd_data;
   assign mem_we    = scan_en && rd_valid && !(wp_q && prot_hit);
   assign cur_addr  = {page_base, wr_off};
endmodule

// File: rtl/pgw_sequencer_chk.sv
module pgw_sequencer_chk #(
   parameter int ADDR_W      = 13,
   parameter int PAGE_BYTES  = 32,
   parameter int BUSY_CYCLES = 1000000,
   parameter int PROT_FRAC   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_addr,
   input logic              byte_stb,
   input logic              commit_stb,
   input logic              wp,
   input logic              busy,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] cur_addr
);
   localparam int PAGE_AW = $clog2(PAGE_BYTES);
   localparam int SEL_W   = $clog2(PROT_FRAC);
   localparam int TOTAL   = PAGE_BYTES + BUSY_CYCLES;

   int   busy_len;
   logic ck_wp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_len <= 0;
         ck_wp    <= 1'b0;
      end else begin
         busy_len <= busy ? busy_len + 1 : 0;
         if (commit_stb && !busy && !load_addr && !byte_stb) ck_wp <= wp;
      end
   end

   // R11
   a_r11_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   a_r11_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:PAGE_AW]));
   // R4
   a_r4_rise_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit_stb));
   a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == TOTAL));
   // R6
   a_r6_frozen_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cur_addr));
   // R2
   a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !busy && !load_addr) |=>
         ((cur_addr[ADDR_W-1:PAGE_AW] == $past(cur_addr[ADDR_W-1:PAGE_AW])) &&
          (cur_addr[PAGE_AW-1:0] == PAGE_AW'($past(cur_addr[PAGE_AW-1:0]) + 1'b1))));
   // R8
   a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && ck_wp) |-> !(&mem_addr[ADDR_W-1 -: SEL_W]));
endmodule

bind pgw_sequencer pgw_sequencer_chk #(
   .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
   .BUSY_CYCLES(BUSY_CYCLES), .PROT_FRAC(PROT_FRAC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .byte_stb(byte_stb),
   .commit_stb(commit_stb), .wp(wp), .busy(busy), .mem_we(mem_we),
   .mem_addr(mem_addr), .cur_addr(cur_addr)
);

// File: tb/tb_pgw_sequencer.sv
module tb_pgw_sequencer;
   localparam int AW = 8, PB = 32, BC = 20, PF = 2;
   localparam int TOTAL = PB + BC;
   localparam int NLOC = 1 << AW;
   localparam int PROT_BASE = NLOC - NLOC / PF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic load_addr = 0, byte_stb = 0, commit_stb = 0, wp = 0;
   logic [AW-1:0] start_addr = '0;
   logic [7:0] byte_data = '0;
   logic busy, mem_we;
   logic [AW-1:0] mem_addr, cur_addr;
   logic [7:0] mem_wdata;

   int checks = 0, errors = 0;

   pgw_sequencer #(.ADDR_W(AW), .PAGE_BYTES(PB), .BUSY_CYCLES(BC), .PROT_FRAC(PF)) dut (
      .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .start_addr(start_addr),
      .byte_stb(byte_stb), .byte_data(byte_data), .commit_stb(commit_stb), .wp(wp),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .cur_addr(cur_addr)
   );

   always #4 clk = ~clk;

   // array model written by the port, plus expected image
   logic [7:0] arr [NLOC];
   logic [7:0] exp_arr [NLOC];
   int wr_cnt [NLOC];
   int commit_writes = 0, order_err = 0, last_wr = -1;

   always @(posedge clk) begin
      if (mem_we) begin
         arr[mem_addr] <= mem_wdata;
         wr_cnt[mem_addr] = wr_cnt[mem_addr] + 1;
         commit_writes = commit_writes + 1;
         if (int'(mem_addr) <= last_wr) order_err = order_err + 1;
         last_wr = int'(mem_addr);
      end
   end

   // bench-side staging model
   logic [7:0] st_d [PB];
   bit st_v [PB];
   int pg = 0, off = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic do_load(input int a);
      load_addr = 1; start_addr = AW'(a);
      @(negedge clk); load_addr = 0;
      pg = a / PB; off = a % PB;
      for (int i = 0; i < PB; i++) st_v[i] = 0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      byte_stb = 1; byte_data = d;
      @(negedge clk); byte_stb = 0;
      st_d[off] = d; st_v[off] = 1; off = (off + 1) % PB;
   endtask

   // commit, optionally flip wp during busy, optionally poke strobes during busy
   task automatic do_commit(input bit wpv, input bit flip, input bit poke, input string req);
      bit nonempty = 0;
      int n, expw, bad, dup;
      for (int i = 0; i < PB; i++) if (st_v[i]) nonempty = 1;
      for (int i = 0; i < NLOC; i++) wr_cnt[i] = 0;
      commit_writes = 0; order_err = 0; last_wr = -1;
      wp = wpv; commit_stb = 1;
      @(negedge clk); commit_stb = 0;
      if (flip) wp = ~wpv;
      if (!nonempty) begin
         for (int k = 0; k < 3; k++) begin
            check(busy == 0, "R7 busy after empty commit", busy, 0);
            @(negedge clk);
         end
         check(commit_writes == 0, "R7 writes after empty commit", commit_writes, 0);
         wp = 0;
         return;
      end
      check(busy == 1, {req, " busy rise"}, busy, 1);
      n = 1;
      while (1) begin
         if (poke && n == 5) begin
            load_addr = 1; start_addr = 8'hE3; byte_stb = 1; byte_data = 8'h5A; commit_stb = 1;
         end
         @(negedge clk);
         load_addr = 0; byte_stb = 0; commit_stb = 0;
         if (poke && n == 5) check(cur_addr == AW'(pg * PB + off), "R6 cur_addr during busy",
                                   cur_addr, pg * PB + off);
         if (!busy) break;
         n++;
         if (n > TOTAL + 10) break;
      end
      check(n == TOTAL, "R4 busy length", n, TOTAL);
      expw = 0;
      for (int o = 0; o < PB; o++) begin
         if (st_v[o]) begin
            int a = pg * PB + o;
            if (!(wpv && a >= PROT_BASE)) begin exp_arr[a] = st_d[o]; expw++; end
         end
         st_v[o] = 0;
      end
      check(commit_writes == expw, {req, " write count"}, commit_writes, expw);
      check(order_err == 0, "R5 ascending order", order_err, 0);
      bad = 0; dup = 0;
      for (int i = 0; i < NLOC; i++) begin
         if (arr[i] !== exp_arr[i]) bad++;
         if (wr_cnt[i] > 1) dup++;
      end
      check(bad == 0, {req, " array contents"}, bad, 0);
      check(dup == 0, "R5 single write per location", dup, 0);
      check(cur_addr == AW'(pg * PB + off), "R10 cur_addr after commit", cur_addr, pg * PB + off);
      wp = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NLOC; i++) begin arr[i] = 0; exp_arr[i] = 0; wr_cnt[i] = 0; end
      for (int i = 0; i < PB; i++) begin st_v[i] = 0; st_d[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 0, "R1 reset busy", busy, 0);
      check(mem_we == 0, "R1 reset mem_we", mem_we, 0);
      check(cur_addr == 0, "R1 reset cur_addr", cur_addr, 0);
      rst_n = 1;
      @(negedge clk);
      // R7 empty commit right after reset
      do_commit(0, 0, 0, "R7");

      // R2 R5 R9: every start offset, three bytes, wp low
      for (int o = 0; o < PB; o++) begin
         int a = (o % (NLOC / PB)) * PB + o;
         do_load(a);
         check(cur_addr == AW'(a), "R1 cur_addr after load", cur_addr, a);
         for (int i = 0; i < 3; i++) begin
            do_byte(8'((o * 37 + i * 11 + 5) & 255));
            check(cur_addr == AW'(pg * PB + off), "R2 offset step", cur_addr, pg * PB + off);
         end
         do_commit(0, 0, 0, "R9");
      end

      // R3 R8 R9: all pages, both protect levels, lengths up to 40 (wrap)
      for (int p = 0; p < NLOC / PB; p++) begin
         for (int w = 0; w < 2; w++) begin
            int o = (p * 7 + w * 13) % PB;
            int len = ((p * 9 + w * 5) % 40) + 1;
            do_load(p * PB + o);
            for (int i = 0; i < len; i++) do_byte(8'((p * 53 + w * 17 + i * 29 + 1) & 255));
            do_commit(w[0], (p == 3), 0, (w == 1) ? "R8" : "R3");
         end
      end

      // R6: strobes during busy are ignored; R10 mask empty afterwards
      do_load(8'h44);
      do_byte(8'hA1); do_byte(8'hB2);
      do_commit(0, 0, 1, "R6");
      do_commit(0, 0, 0, "R10");

      // R1: reload discards earlier staged bytes
      do_load(8'h10);
      do_byte(8'hC3); do_byte(8'hD4);
      do_load(8'h9E);
      do_byte(8'hE5);
      do_commit(0, 0, 0, "R1");

      // R12: load wins over byte in the same cycle; byte wins over commit
      load_addr = 1; start_addr = 8'h27; byte_stb = 1; byte_data = 8'h77;
      @(negedge clk); load_addr = 0; byte_stb = 0;
      pg = 1; off = 7; for (int i = 0; i < PB; i++) st_v[i] = 0;
      check(cur_addr == 8'h27, "R12 load over byte", cur_addr, 8'h27);
      byte_stb = 1; byte_data = 8'h66; commit_stb = 1;
      @(negedge clk); byte_stb = 0; commit_stb = 0;
      st_d[7] = 8'h66; st_v[7] = 1; off = 8;
      check(busy == 0, "R12 byte over commit busy", busy, 0);
      check(cur_addr == 8'h28, "R12 byte over commit addr", cur_addr, 8'h28);
      do_commit(1, 0, 0, "R12");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule